// File: doc/BRIEF.md
# Packed Vector Arithmetic Unit

This unit is the arithmetic core of a video-processing datapath. Each issued operation takes two 128-bit operand vectors (`src_a`, `src_b`), a third vector (`src_d`) that carries either the old destination contents or a permute control word, a 4-bit opcode and a lane-width flag. It returns one 128-bit result vector one clock later. The same 128 bits are read either as eight 16-bit lanes or as four 32-bit lanes, and the choice is made per operation. No lane ever carries into its neighbour.

The lane operations are wrap-around add and subtract, three shift kinds, bitwise logic, compares that write lane masks, and a masked merge. A gather operation rearranges 16-bit pixel elements taken from both sources. A bank of eight 40-bit accumulators sits behind signed 16x18 multipliers. In 32-bit mode the multipliers take a full 18-bit coefficient, so colour-conversion constants fit without extra steps. The accumulators can be cleared, restarted, accumulated into and read back through an arithmetic right shift.

Control is a two-state machine. `ST_IDLE` means no result was issued last cycle. `ST_ISSUE` means the result register holds the output of the operation accepted at the previous edge. The transition *accept* (`in_valid` high) goes from either state to `ST_ISSUE`. The transition *drain* (`in_valid` low) goes from either state to `ST_IDLE`.

Top module: `simd_vec_alu`

## Requirements
- R1: After reset `out_valid` is 0, `result` is all zeros and every accumulator holds zero.
- R2: An operation accepted with `in_valid` at a rising edge drives `out_valid` high and its value on `result` after that edge. A cycle without `in_valid` drops `out_valid` and leaves `result` unchanged.
- R3: With `wide`=0 the vectors are eight 16-bit lanes (lane i = bits 16i+15..16i); with `wide`=1 they are four 32-bit lanes. Opcode 0 adds and opcode 1 subtracts (A-B) per lane, modulo the lane width, with no carry between lanes.
- R4: The shift amount is the low 4 bits (16-bit lanes) or low 5 bits (32-bit lanes) of each B lane. Opcode 2 shifts A right arithmetically, opcode 3 shifts it right logically, and opcode 4 shifts it left.
- R5: Opcodes 5, 6 and 7 give the bitwise AND, OR and XOR of A and B.
- R6: Opcode 8 (A equals B) and opcode 9 (A greater than B, both signed) write all-ones into a lane where the test holds and all-zeros where it fails.
- R7: Opcode 10 uses B as a mask. A lane comes from A where the B lane is all-ones and from D in every other case, including partial masks.
- R8: Opcode 11 builds output 16-bit lane j from control nibble D[4j+3:4j]. Bit 3 picks the source (0 = A, 1 = B) and bits 2..0 pick which of that source's eight 16-bit elements is taken. `wide` is ignored.
- R9: Opcode 12 adds a signed product into each active 40-bit accumulator, modulo 2^40. With `wide`=0, accumulator i takes A lane i times the sign-extended B lane i. With `wide`=1, accumulators 0..3 take bits 15..0 of A lane i times bits 17..0 of B lane i, and accumulators 4..7 are left unchanged. The result is all zeros.
- R10: Opcode 13 behaves as opcode 12 except that each active accumulator is loaded with the product and its old value is discarded.
- R11: Opcode 14 returns accumulator i shifted right arithmetically by B[5:0] and truncated into lane i (8 lanes when `wide`=0, 4 lanes when `wide`=1). The accumulators are not changed.
- R12: Opcode 15 clears all eight accumulators and returns all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation issued this cycle |
| opcode | input | 4 | Operation code (see requirements) |
| wide | input | 1 | 0: eight 16-bit lanes, 1: four 32-bit lanes |
| src_a | input | 128 | First operand vector |
| src_b | input | 128 | Second operand, mask, shift amounts or coefficients |
| src_d | input | 128 | Old destination for merge, control for gather |
| out_valid | output | 1 | `result` holds a freshly issued value |
| result | output | 128 | Registered result vector |

## Verification
The embedded properties check the same things on every cycle. The one-cycle issue latency holds, and `result` stays put while idle. A compare always leaves a full lane mask. Lane-0 addition never picks up bits from elsewhere. A clear empties every accumulator by the next edge. What no property can cover is the arithmetic of the other lanes and opcodes, the behaviour of accumulators across long chains of multiply-accumulate, restart and readout, the 18-bit coefficient range and gather indexing. These are shown by the bench scenarios, which compare against a lane-by-lane reference model fed both random vectors and chosen edge values.

// File: rtl/simd_pkg.sv
package simd_pkg;
    localparam int VEC_W  = 128;
    localparam int N16    = VEC_W / 16;
    localparam int N32    = VEC_W / 32;
    localparam int ACC_W  = 40;
    localparam int SEL_W  = 4;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,  OP_SUB  = 4'd1,  OP_SRA  = 4'd2,  OP_SRL  = 4'd3,
        OP_SLL  = 4'd4,  OP_AND  = 4'd5,  OP_OR   = 4'd6,  OP_XOR  = 4'd7,
        OP_CEQ  = 4'd8,  OP_CGT  = 4'd9,  OP_CMOV = 4'd10, OP_SEL  = 4'd11,
        OP_MAC  = 4'd12, OP_MACZ = 4'd13, OP_ACRD = 4'd14, OP_ACLR = 4'd15
    } op_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } state_e;
endpackage

// File: rtl/vec_lane_op.sv
module vec_lane_op
    import simd_pkg::*;
#(
    parameter int W = 16
) (
    input  op_e          op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] d,
    output logic [W-1:0] y
);
    localparam int SHW = $clog2(W);

    logic [SHW-1:0] sh;
    assign sh = b[SHW-1:0];

    always_comb begin
        unique case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_SRA:  y = $signed(a) >>> sh;
            OP_SRL:  y = a >> sh;
            OP_SLL:  y = a << sh;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_CEQ:  y = {W{a == b}};
            OP_CGT:  y = {W{$signed(a) > $signed(b)}};
            OP_CMOV: y = (&b) ? a : d;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/vec_gather.sv
module vec_gather
    import simd_pkg::*;
(
    input  logic [VEC_W-1:0] a,
    input  logic [VEC_W-1:0] b,
    input  logic [VEC_W-1:0] ctl,
    output logic [VEC_W-1:0] y
);
    for (genvar j = 0; j < N16; j++) begin : g_out
        logic [SEL_W-1:0]  c;
        logic [VEC_W-1:0]  src;
        assign c   = ctl[SEL_W*j +: SEL_W];
        assign src = c[SEL_W-1] ? b : a;
        assign y[16*j +: 16] = src[16*c[SEL_W-2:0] +: 16];
    end
endmodule

// File: rtl/mac_bank.sv
module mac_bank
    import simd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_en,
    input  logic             acc_load,
    input  logic             acc_clr,
    input  logic             wide,
    input  logic [VEC_W-1:0] a,
    input  logic [VEC_W-1:0] b,
    input  logic [5:0]       sh,
    output logic [VEC_W-1:0] rd
);
    logic [VEC_W-1:0] rd16;
    logic [VEC_W-1:0] rd32;

    for (genvar i = 0; i < N16; i++) begin : g_lane
        localparam int WI = (i < N32) ? i : 0;
        localparam bit HAS_WIDE = (i < N32);

        logic signed [15:0]      ma;
        logic signed [17:0]      mb;
        logic signed [ACC_W-1:0] prod;
        logic signed [ACC_W-1:0] acc;
        logic signed [ACC_W-1:0] shifted;
        logic                    lane_on;

        always_comb begin
            if (wide) begin
                ma = a[32*WI +: 16];
                mb = b[32*WI +: 18];
            end else begin
                ma = a[16*i +: 16];
                mb = 18'($signed(b[16*i +: 16]));
            end
            prod    = ACC_W'(ma) * ACC_W'(mb);
            lane_on = wide ? HAS_WIDE : 1'b1;
            shifted = acc >>> sh;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                acc <= '0;
            else if (acc_clr)          acc <= '0;
            else if (acc_en && lane_on) acc <= (acc_load ? '0 : acc) + prod;
        end

        assign rd16[16*i +: 16] = shifted[15:0];
        if (HAS_WIDE) begin : g_w
            assign rd32[32*i +: 32] = shifted[31:0];
        end

        AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
            acc_clr |=> (acc == '0)); // R12
    end

    assign rd = wide ? rd32 : rd16;
endmodule

// File: rtl/simd_vec_alu.sv
module simd_vec_alu
    import simd_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [3:0]   opcode,
    input  logic         wide,
    input  logic [127:0] src_a,
    input  logic [127:0] src_b,
    input  logic [127:0] src_d,
    output logic         out_valid,
    output logic [127:0] result
);
    op_e              op;
    state_e           state, state_n;
    logic [VEC_W-1:0] r16, r32, sel_y, acc_rd, res_n;

    assign op = op_e'(opcode);

    for (genvar i = 0; i < N16; i++) begin : g_l16
        vec_lane_op #(.W(16)) u_lane (
            .op(op), .a(src_a[16*i +: 16]), .b(src_b[16*i +: 16]),
            .d(src_d[16*i +: 16]), .y(r16[16*i +: 16]));
    end

    for (genvar i = 0; i < N32; i++) begin : g_l32
        vec_lane_op #(.W(32)) u_lane (
            .op(op), .a(src_a[32*i +: 32]), .b(src_b[32*i +: 32]),
            .d(src_d[32*i +: 32]), .y(r32[32*i +: 32]));
    end

    vec_gather u_gather (.a(src_a), .b(src_b), .ctl(src_d), .y(sel_y));

    mac_bank u_mac (
        .clk(clk), .rst_n(rst_n),
        .acc_en(in_valid && (op == OP_MAC || op == OP_MACZ)),
        .acc_load(op == OP_MACZ),
        .acc_clr(in_valid && op == OP_ACLR),
        .wide(wide), .a(src_a), .b(src_b), .sh(src_b[5:0]), .rd(acc_rd));

    always_comb begin
        unique case (op)
            OP_SEL:                    res_n = sel_y;
            OP_ACRD:                   res_n = acc_rd;
            OP_MAC, OP_MACZ, OP_ACLR:  res_n = '0;
            default:                   res_n = wide ? r32 : r16;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    always_comb begin
        unique case (state)
            ST_IDLE:  state_n = in_valid ? ST_ISSUE : ST_IDLE;
            ST_ISSUE: state_n = in_valid ? ST_ISSUE : ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        result <= '0;
        else if (in_valid) result <= res_n;
    end

    assign out_valid = (state == ST_ISSUE);

    AST_ISSUE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result))); // R2
    AST_CMP_FULL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !wide && (op == OP_CEQ || op == OP_CGT)) |=>
        ($countones(result[15:0]) == 0 || $countones(result[15:0]) == 16)); // R6
    AST_ADD_LANE_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !wide && op == OP_ADD) |=>
        (result[15:0] == 16'($past(src_a[15:0]) + $past(src_b[15:0])))); // R3
endmodule

// File: tb/test_simd_vec_alu.sv
`timescale 1ns/1ps
module test_simd_vec_alu;
    logic         clk = 0;
    logic         rst_n = 0;
    logic         in_valid = 0;
    logic [3:0]   opcode = 0;
    logic         wide = 0;
    logic [127:0] src_a = 0, src_b = 0, src_d = 0;
    logic         out_valid;
    logic [127:0] result;

    int n_chk = 0, n_bad = 0;
    logic signed [39:0] macc [8];

    always #2 clk = ~clk;

    simd_vec_alu i_simd_vec_alu (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .opcode(opcode), .wide(wide), .src_a(src_a), .src_b(src_b), .src_d(src_d),
        .out_valid(out_valid), .result(result));

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] lane_model(input logic [3:0] op, input int w,
            input logic [127:0] a, input logic [127:0] b, input logic [127:0] d);
        logic [127:0] r = '0;
        logic [31:0] mask = (w == 16) ? 32'hFFFF : 32'hFFFF_FFFF;
        for (int i = 0; i < 128 / w; i++) begin
            logic [31:0] x, y, z, o;
            logic signed [31:0] sx, sy;
            int sh;
            x = 32'(a >> (i * w)) & mask;
            y = 32'(b >> (i * w)) & mask;
            z = 32'(d >> (i * w)) & mask;
            sx = (w == 16) ? {{16{x[15]}}, x[15:0]} : x;
            sy = (w == 16) ? {{16{y[15]}}, y[15:0]} : y;
            sh = int'(y & 32'(w - 1));
            case (op)
                0: o = x + y;
                1: o = x - y;
                2: o = 32'(sx >>> sh);
                3: o = x >> sh;
                4: o = x << sh;
                5: o = x & y;
                6: o = x | y;
                7: o = x ^ y;
                8: o = (x == y) ? 32'hFFFF_FFFF : 0;
                9: o = (sx > sy) ? 32'hFFFF_FFFF : 0;
                10: o = (y == mask) ? x : z;
                default: o = 0;
            endcase
            r |= 128'(o & mask) << (i * w);
        end
        return r;
    endfunction

    task automatic model(input logic [3:0] op, input logic wd, input logic [127:0] a,
            input logic [127:0] b, input logic [127:0] d, output logic [127:0] r);
        r = '0;
        if (op <= 10) r = lane_model(op, wd ? 32 : 16, a, b, d);
        else if (op == 11) begin
            for (int j = 0; j < 8; j++) begin
                logic [3:0] c = d[4*j +: 4];
                logic [127:0] s = c[3] ? b : a;
                r[16*j +: 16] = s[16*c[2:0] +: 16];
            end
        end else if (op == 12 || op == 13) begin
            for (int i = 0; i < 8; i++) begin
                logic signed [15:0] sa;
                logic signed [17:0] sb;
                logic signed [39:0] p;
                if (wd && i >= 4) continue;
                if (!wd) begin sa = a[16*i +: 16]; sb = 18'($signed(b[16*i +: 16])); end
                else begin sa = a[32*i +: 16]; sb = b[32*i +: 18]; end
                p = sa * sb;
                macc[i] = ((op == 13) ? 40'sd0 : macc[i]) + p;
            end
        end else if (op == 14) begin
            for (int i = 0; i < 8; i++) begin
                logic signed [39:0] t = macc[i] >>> b[5:0];
                if (!wd) r[16*i +: 16] = t[15:0];
                else if (i < 4) r[32*i +: 32] = t[31:0];
            end
        end else begin
            for (int i = 0; i < 8; i++) macc[i] = 0;
        end
    endtask

    task automatic run(input string req, input logic [3:0] op, input logic wd,
            input logic [127:0] a, input logic [127:0] b, input logic [127:0] d);
        logic [127:0] exp;
        @(negedge clk);
        opcode = op; wide = wd; src_a = a; src_b = b; src_d = d; in_valid = 1;
        model(op, wd, a, b, d, exp);
        @(negedge clk);
        in_valid = 0;
        check({req, " valid"}, 128'(out_valid), 128'(1));
        check(req, result, exp);
    endtask

    function automatic logic [127:0] rnd();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [127:0] held;
        void'($urandom(32'd20240517));
        for (int i = 0; i < 8; i++) macc[i] = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 out_valid", 128'(out_valid), 0);
        check("R1 result", result, 0);
        rst_n = 1;
        run("R1 acc zero after reset", 14, 0, rnd(), 128'd0, 0);
        // R3 carry stays inside a lane
        run("R3 narrow add wrap", 0, 0, 128'hFFFF, 128'h1, 0);
        check("R3 narrow lane0 zero", result, 0);
        run("R3 wide add carry", 0, 1, 128'hFFFF, 128'h1, 0);
        check("R3 wide literal", result, 128'h10000);
        run("R3 sub borrow", 1, 0, 128'h0, 128'h1, 0);
        // R4 shifts
        run("R4 sra narrow", 2, 0, 128'h8000, 128'hF, 0);
        check("R4 sra literal", result, 128'hFFFF);
        run("R4 srl wide", 3, 1, {4{32'h8000_0000}}, {4{32'd31}}, 0);
        run("R4 sll narrow", 4, 0, rnd(), rnd(), 0);
        // R5 logic
        run("R5 and", 5, 0, rnd(), rnd(), 0);
        run("R5 or", 6, 1, rnd(), rnd(), 0);
        run("R5 xor", 7, 0, rnd(), rnd(), 0);
        // R6 compare
        run("R6 ceq", 8, 0, {8{16'h1234}}, {4{32'h1234_5678}}, 0);
        run("R6 cgt signed", 9, 1, {4{32'h0000_0001}}, {4{32'hFFFF_FFFF}}, 0);
        // R7 merge with partial mask
        run("R7 cmov partial", 10, 0, {8{16'hAAAA}}, {16'hFFFF, 16'h7FFF, 96'h0},
            {8{16'h5555}});
        check("R7 literal", result, {16'hAAAA, {7{16'h5555}}});
        // R8 gather
        run("R8 select", 11, 1, rnd(), rnd(), 128'h0000_0000_0000_0000_0000_0000_0123_F8A7);
        // R12 clear, R9 wide 18-bit coefficient
        run("R12 clear", 15, 0, rnd(), rnd(), 0);
        run("R9 narrow mac", 12, 0, {8{16'd3}}, {8{16'hFFFE}}, 0);
        run("R9 wide mac 18b", 12, 1, {4{32'd2}}, {4{32'h0002_0000}}, 0);
        run("R11 wide read", 14, 1, 0, 128'd0, 0);
        check("R11 literal lane0", 128'(result[31:0]), 128'(32'hFFFB_FFFA));
        run("R9 upper accs untouched", 14, 0, 0, 128'd0, 0);
        run("R10 restart", 13, 0, {8{16'd7}}, {8{16'd5}}, 0);
        run("R11 shifted read", 14, 0, 0, 128'd1, 0);
        run("R12 clear again", 15, 1, rnd(), rnd(), 0);
        run("R12 acc zero", 14, 1, 0, 128'd0, 0);
        // R2 hold while idle
        held = result;
        @(negedge clk);
        check("R2 idle valid", 128'(out_valid), 0);
        check("R2 idle hold", result, held);
        // random mix
        for (int k = 0; k < 400; k++) begin
            logic [3:0] op = 4'($urandom % 16);
            logic [127:0] b = rnd();
            if (op == 10 && k[0]) b = {{2{16'hFFFF}}, b[95:0]};
            if (op == 14) b = 128'($urandom % 40);
            run($sformatf("R3-op%0d random", op), op, 1'($urandom), rnd(), b, rnd());
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule